// File: doc/BRIEF.md
# Hermitian Correlation Matrix Accumulator

This block builds a sample correlation matrix from a stream of complex sample vectors. Each accepted vector `y` contributes the outer product `y * conj(y)^T` to a running matrix Q. The sum runs over a frame whose length in vectors is programmable. When the last vector of a frame has been added, a one-cycle pulse marks the frame as complete, and the finished matrix stays readable until the next vector arrives.

Q is Hermitian, so the block keeps only the diagonal and the upper triangle. That is N(N+1)/2 complex accumulators. Each diagonal accumulator is real and is fed by two squarings. Each upper entry is fed by four real products. A combinational read port takes a row and a column index. It serves lower-triangle positions by conjugating the mirrored stored entry. The first vector of each frame replaces the accumulator contents instead of adding to them, so frames can follow each other with no idle cycle.

Sample components are signed 18-bit fixed point with 16 fractional bits. Products carry 32 fractional bits. Accumulators are widened so that a full frame of full-scale inputs cannot wrap.

Top module: `hcorr_acc`

## Requirements
- R1: After reset, `frame_done_o` is low and every in-range read returns zero on both the real and the imaginary output.
- R2: A read of a diagonal position (i,i) returns the sum over the frame of `re(y_i)^2 + im(y_i)^2`, with an imaginary part of exactly zero.
- R3: A read of (i,j) with i < j returns the frame sum of `y_i * conj(y_j)`. The real part is `re_i*re_j + im_i*im_j` and the imaginary part is `im_i*re_j - re_i*im_j`.
- R4: A read of (i,j) with i > j returns the stored (j,i) entry with its imaginary part negated.
- R5: A cycle with `vec_valid_i` low neither counts toward the frame nor changes Q. `frame_done_o` is high for exactly the one cycle after the clock edge that accepts the last vector of a frame.
- R6: The first vector of each frame restarts accumulation, so no contribution from an earlier frame remains in Q.
- R7: Vectors may arrive on every cycle across a frame boundary, including the cycle in which `frame_done_o` is high. No vector is dropped, and the completed frame is readable in the done cycle.
- R8: A frame-length value of 0 means 2^LEN_W vectors. Full-scale inputs over the longest frame accumulate exactly, with no wrap.
- R9: A read with a row or column index of N or more returns zero on both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_len_i | input | LEN_W | Vectors per frame; 0 means 2^LEN_W |
| vec_valid_i | input | 1 | Vector on the sample inputs is accepted at this edge |
| vec_re_i | input | N*DW | Real parts; element k in bits [k*DW +: DW], signed |
| vec_im_i | input | N*DW | Imaginary parts, same packing |
| frame_done_o | output | 1 | One-cycle pulse after the last vector of a frame |
| rd_row_i | input | IW | Read row index (IW = clog2(N)+1) |
| rd_col_i | input | IW | Read column index |
| rd_re_o | output | AW | Real part of Q(row,col), signed |
| rd_im_o | output | AW | Imaginary part of Q(row,col), signed |

## Verification
The assertions assume that `frame_len_i` does not change in the middle of a frame. They also assume that the read indices are stable across an idle cycle whenever read data is expected to hold. The stimulus changes the frame length only while the block is idle between frames. It moves the read indices only while `vec_valid_i` is low, or, during a frame boundary, within the half cycle before a vector edge. The sample values stay within the 18-bit signed range. The full-scale frame uses the most negative code, so the accumulator width is tested at its actual limit.

// File: rtl/hcorr_pkg.sv
package hcorr_pkg;
  // linear slot of upper-triangle entry (r,c), r <= c, in an n x n matrix
  function automatic int tri_idx(int r, int c, int n);
    return r * n - (r * (r - 1)) / 2 + (c - r);
  endfunction
endpackage

// File: rtl/hcorr_cmul.sv
module hcorr_cmul #(
  parameter int DW   = 18,
  parameter int AW   = 46,
  parameter bit DIAG = 1'b0
) (
  input  logic signed [DW-1:0] a_re_i,
  input  logic signed [DW-1:0] a_im_i,
  input  logic signed [DW-1:0] b_re_i,
  input  logic signed [DW-1:0] b_im_i,
  output logic signed [AW-1:0] p_re_o,
  output logic signed [AW-1:0] p_im_o
);
  logic signed [AW-1:0] ar, ai, br, bi;
  assign ar = AW'(a_re_i);
  assign ai = AW'(a_im_i);
  assign br = AW'(b_re_i);
  assign bi = AW'(b_im_i);

  // a * conj(b)
  if (DIAG) begin : g_diag
    logic unused_b;
    assign unused_b = ^{br, bi};
    assign p_re_o = ar * ar + ai * ai;
    assign p_im_o = '0;
  end else begin : g_off
    assign p_re_o = ar * br + ai * bi;
    assign p_im_o = ai * br - ar * bi;
  end
endmodule

// File: rtl/hcorr_frame_ctl.sv
module hcorr_frame_ctl #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic             vec_valid_i,
  output logic             first_o,
  output logic             done_o
);
  logic [LEN_W-1:0] cnt_q;
  logic             last;

  // length 0 wraps to all-ones, giving 2^LEN_W vectors
  assign last    = (cnt_q == frame_len_i - LEN_W'(1));
  assign first_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= vec_valid_i && last;
      if (vec_valid_i) cnt_q <= last ? '0 : cnt_q + LEN_W'(1);
    end
  end
endmodule

// File: rtl/hcorr_rd_mux.sv
module hcorr_rd_mux
  import hcorr_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 46,
  parameter int IW = 3,
  parameter int T  = 10
) (
  input  logic [IW-1:0]        row_i,
  input  logic [IW-1:0]        col_i,
  input  logic [T*AW-1:0]      re_flat_i,
  input  logic [T*AW-1:0]      im_flat_i,
  output logic signed [AW-1:0] re_o,
  output logic signed [AW-1:0] im_o
);
  int r, c, k;
  logic swap;
  logic signed [AW-1:0] im_raw;

  always_comb begin
    re_o   = '0;
    im_o   = '0;
    im_raw = '0;
    swap   = row_i > col_i;
    r      = swap ? int'(col_i) : int'(row_i);
    c      = swap ? int'(row_i) : int'(col_i);
    k      = 0;
    if (int'(row_i) < N && int'(col_i) < N) begin
      k      = tri_idx(r, c, N);
      re_o   = re_flat_i[k*AW +: AW];
      im_raw = im_flat_i[k*AW +: AW];
      if (r == c)    im_o = '0;
      else if (swap) im_o = -im_raw;
      else           im_o = im_raw;
    end
  end
endmodule

// File: rtl/hcorr_acc.sv
module hcorr_acc
  import hcorr_pkg::*;
#(
  parameter int N     = 4,
  parameter int DW    = 18,
  parameter int LEN_W = 8,
  localparam int IW   = $clog2(N) + 1,
  localparam int AW   = 2 * DW + LEN_W + 2,
  localparam int T    = N * (N + 1) / 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [LEN_W-1:0]     frame_len_i,
  input  logic                 vec_valid_i,
  input  logic [N*DW-1:0]      vec_re_i,
  input  logic [N*DW-1:0]      vec_im_i,
  output logic                 frame_done_o,
  input  logic [IW-1:0]        rd_row_i,
  input  logic [IW-1:0]        rd_col_i,
  output logic signed [AW-1:0] rd_re_o,
  output logic signed [AW-1:0] rd_im_o
);
  logic            first;
  logic [T*AW-1:0] re_flat, im_flat;

  hcorr_frame_ctl #(.LEN_W(LEN_W)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_len_i (frame_len_i),
    .vec_valid_i (vec_valid_i),
    .first_o     (first),
    .done_o      (frame_done_o)
  );

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = r; c < N; c++) begin : g_col
      localparam int K = tri_idx(r, c, N);
      logic signed [AW-1:0] p_re, p_im, acc_re_q;

      hcorr_cmul #(.DW(DW), .AW(AW), .DIAG(r == c)) u_mul (
        .a_re_i (vec_re_i[r*DW +: DW]),
        .a_im_i (vec_im_i[r*DW +: DW]),
        .b_re_i (vec_re_i[c*DW +: DW]),
        .b_im_i (vec_im_i[c*DW +: DW]),
        .p_re_o (p_re),
        .p_im_o (p_im)
      );

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          acc_re_q <= '0;
        else if (vec_valid_i) acc_re_q <= first ? p_re : acc_re_q + p_re;
      end
      assign re_flat[K*AW +: AW] = acc_re_q;

      if (r == c) begin : g_real
        logic unused_im;
        assign unused_im = ^p_im;
        assign im_flat[K*AW +: AW] = '0;
      end else begin : g_cplx
        logic signed [AW-1:0] acc_im_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)          acc_im_q <= '0;
          else if (vec_valid_i) acc_im_q <= first ? p_im : acc_im_q + p_im;
        end
        assign im_flat[K*AW +: AW] = acc_im_q;
      end
    end
  end

  hcorr_rd_mux #(.N(N), .AW(AW), .IW(IW), .T(T)) u_rd (
    .row_i     (rd_row_i),
    .col_i     (rd_col_i),
    .re_flat_i (re_flat),
    .im_flat_i (im_flat),
    .re_o      (rd_re_o),
    .im_o      (rd_im_o)
  );
endmodule

// File: rtl/hcorr_acc_chk.sv
module hcorr_acc_chk #(
  parameter int N  = 4,
  parameter int IW = 3,
  parameter int AW = 46
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          vec_valid_i,
  input logic          frame_done_o,
  input logic [IW-1:0] rd_row_i,
  input logic [IW-1:0] rd_col_i,
  input logic [AW-1:0] rd_re_o,
  input logic [AW-1:0] rd_im_o
);
  a_r2_diag_real: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_row_i == rd_col_i && int'(rd_row_i) < N) |-> rd_im_o == '0);

  a_r9_oob_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(rd_row_i) >= N || int'(rd_col_i) >= N) |-> (rd_re_o == '0 && rd_im_o == '0));

  a_r5_done_after_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_done_o) |-> $past(vec_valid_i));

  a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_valid_i ##1 ($stable(rd_row_i) && $stable(rd_col_i))
      |-> ($stable(rd_re_o) && $stable(rd_im_o)));
endmodule

bind hcorr_acc hcorr_acc_chk #(.N(N), .IW(IW), .AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .vec_valid_i  (vec_valid_i),
  .frame_done_o (frame_done_o),
  .rd_row_i     (rd_row_i),
  .rd_col_i     (rd_col_i),
  .rd_re_o      (rd_re_o),
  .rd_im_o      (rd_im_o)
);

// File: tb/sim_hcorr_acc.sv
module sim_hcorr_acc;
  localparam int N = 4, DW = 18, LEN_W = 8;
  localparam int IW = $clog2(N) + 1;
  localparam int AW = 2 * DW + LEN_W + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LEN_W-1:0] frame_len = '0;
  logic vec_valid = 1'b0;
  logic [N*DW-1:0] vre = '0, vim = '0;
  logic frame_done;
  logic [IW-1:0] rd_row = '0, rd_col = '0;
  logic signed [AW-1:0] rre, rim;

  int n_checks = 0, n_errors = 0, cycles = 0;
  int yr[N], yi[N];
  longint er[N][N], ei[N][N];
  int mcnt = 0, mlen = 1;

  always #10 clk = ~clk;

  hcorr_acc #(.N(N), .DW(DW), .LEN_W(LEN_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_len_i(frame_len), .vec_valid_i(vec_valid),
    .vec_re_i(vre), .vec_im_i(vim), .frame_done_o(frame_done),
    .rd_row_i(rd_row), .rd_col_i(rd_col), .rd_re_o(rre), .rd_im_o(rim));

  task automatic check(string req, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_errors++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      summary();
    end
  end

  task automatic gen(int s);
    for (int i = 0; i < N; i++) begin
      yr[i] = (((s * 7919 + i * 104729) % 60001) - 30000) * 4;
      yi[i] = (((s * 3571 + i * 65537 + 11) % 60001) - 30000) * 4;
    end
  endtask

  task automatic gen_full();
    for (int i = 0; i < N; i++) begin
      yr[i] = (i % 2 == 0) ? -131072 : 131071;
      yi[i] = (i < 2) ? -131072 : 131071;
    end
  endtask

  // call right after a negedge: drive current yr/yi and update the model
  task automatic drive_vec();
    for (int i = 0; i < N; i++) begin
      vre[i*DW +: DW] = DW'(yr[i]);
      vim[i*DW +: DW] = DW'(yi[i]);
    end
    vec_valid = 1'b1;
    if (mcnt == 0)
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin er[i][j] = 0; ei[i][j] = 0; end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        er[i][j] += longint'(yr[i]) * yr[j] + longint'(yi[i]) * yi[j];
        ei[i][j] += longint'(yi[i]) * yr[j] - longint'(yr[i]) * yi[j];
      end
    mcnt++;
    if (mcnt == mlen) mcnt = 0;
  endtask

  task automatic read_one(string req, int r, int c);
    rd_row = IW'(r); rd_col = IW'(c);
    #1;
    check(req, longint'(rre), er[r][c]);
    check(req, longint'(rim), ei[r][c]);
  endtask

  task automatic check_all();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        read_one(r == c ? "R2 diag" : (r < c ? "R3 upper" : "R4 lower"), r, c);
  endtask

  task automatic set_len(int len);
    @(negedge clk);
    vec_valid = 1'b0;
    frame_len = LEN_W'(len);
    mlen = (len == 0) ? (1 << LEN_W) : len;
    mcnt = 0;
  endtask

  task automatic run_frame(int len, int seed, bit gaps, bit full);
    set_len(len);
    for (int v = 0; v < mlen; v++) begin
      @(negedge clk);
      if (full) gen_full(); else gen(seed + v);
      drive_vec();
      if (gaps && v < mlen - 1) begin
        @(negedge clk);
        vec_valid = 1'b0;
        check("R5 gap no done", longint'(frame_done), 0);
        @(negedge clk);
        check("R5 gap no done", longint'(frame_done), 0);
      end
    end
    @(negedge clk);
    vec_valid = 1'b0;
    check("R5 done pulse", longint'(frame_done), 1);
    @(negedge clk);
    check("R5 done single", longint'(frame_done), 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin er[i][j] = 0; ei[i][j] = 0; end
    #35 rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    check("R1 done low", longint'(frame_done), 0);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) read_one("R1 zero", r, c);

    run_frame(1, 5, 1'b0, 1'b0);
    check_all();
    // R5 with gaps, then R6 restart
    run_frame(3, 40, 1'b1, 1'b0);
    check_all();
    run_frame(4, 90, 1'b0, 1'b0);
    read_one("R6 restart", 0, 0);
    read_one("R6 restart", 1, 3);
    check_all();

    // R7: three frames of two vectors back to back
    set_len(2);
    for (int v = 0; v < 6; v++) begin
      @(negedge clk);
      if (v == 2 || v == 4) begin
        check("R7 done in stream", longint'(frame_done), 1);
        read_one("R7 frame visible", 2, 3);
        read_one("R7 frame visible", 3, 1);
      end
      gen(200 + v * 3);
      drive_vec();
    end
    @(negedge clk);
    vec_valid = 1'b0;
    check("R7 final done", longint'(frame_done), 1);
    @(negedge clk);
    check_all();

    // R8: longest frame, full scale
    run_frame(0, 0, 1'b0, 1'b1);
    read_one("R8 full scale", 0, 0);
    read_one("R8 full scale", 0, 3);
    check_all();

    // R9: out of range
    rd_row = IW'(N); rd_col = '0; #1;
    check("R9 oob re", longint'(rre), 0);
    check("R9 oob im", longint'(rim), 0);
    rd_row = '1; rd_col = '1; #1;
    check("R9 oob re", longint'(rre), 0);
    check("R9 oob im", longint'(rim), 0);
    rd_row = 1; rd_col = IW'(N + 1); #1;
    check("R9 oob re", longint'(rre), 0);

    @(negedge clk);
    summary();
  end
endmodule